// File: doc/BRIEF.md
# Multiplexed GPIO port controller

This block is an eight-pin general-purpose I/O port that sits behind a simple register bus. Software can drive a pin from a data latch or read it back, with a per-pin direction bit that selects which. On-chip peripherals can also take a pin over. These are two CAN controllers, each with one transmit pin and one receive pin, and one SPI unit with four pins. Each pin goes to the enabled peripheral of highest priority that maps onto it. The order is CAN0, then CAN4, then SPI0, and plain GPIO comes last.

The block drives the output enable and output value of each pad and takes the pad input levels. Pad inputs pass through a two-flop synchronizer. Register reads and the receive signals handed to the peripherals use the synchronized levels. A three-bit route select moves each peripheral's pins to an alternate position. A peripheral that is disabled claims no pins, so its route bit then has no effect.

Bus writes take effect on the clock edge on which the write strobe is high. Read data is combinational from the address.

Top module: `gpio_mux_port`

## Requirements
- R1: Pin ownership is decided by fixed priority: CAN0 over CAN4 over SPI0 over GPIO. A pin claimed by a higher peripheral is never driven by a lower one.
- R2: While reset is asserted, the data latch and the direction register clear to 0x00. With no peripheral enabled, every pad_oe bit is then 0.
- R3: A pin owned by a CAN transmitter has pad_oe=1 and pad_out equal to the TX input. A pin owned by a CAN receiver has pad_oe=0. The rx output equals the synchronized pad bit while that CAN controller is enabled, and 1 while it is disabled.
- R4: route_sel bit 0 moves CAN0 tx/rx from pins 1/0 to pins 3/2. Bit 1 moves CAN4 tx/rx from pins 7/6 to pins 5/4. Bit 2 moves SPI0 SCK/MOSI/SS/MISO from pins 7/6/5/4 to pins 3/2/1/0. A route bit has no effect while its peripheral is disabled.
- R5: For SPI0-owned pins with spi_master=1, SCK, MOSI and SS are outputs carrying spi_sck_o, spi_mosi_o and spi_ss_o, and MISO is an input. With spi_master=0, MISO is an output carrying spi_miso_o and the other three are inputs. The spi_*_i outputs carry the synchronized pad bit of an owned SPI pin and are 0 otherwise.
- R6: A GPIO-owned pin has pad_oe equal to its direction bit and pad_out equal to its latch bit. pad_out is 0 on every pin whose pad_oe is 0.
- R7: The data register is at address 0x10. A read returns the latch bit where the direction bit is 1 and the synchronized pad bit where it is 0.
- R8: The input register at address 0x11 reads the synchronized pad levels of all eight pins, whatever the ownership. A write to 0x11 changes neither the latch nor the direction register.
- R9: The direction register is at address 0x12 and is read/write. Reads of any other address return 0x00, and writes to any other address change nothing.
- R10: Writes to the data latch take effect while a peripheral owns the pin. The written value drives the pin once the peripheral is disabled.
- R11: A pad level change is seen by register reads and by the peripheral rx outputs after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| route_sel | input | 3 | Alternate routing: bit0 CAN0, bit1 CAN4, bit2 SPI0 |
| can0_en | input | 1 | CAN0 enable |
| can0_tx | input | 1 | CAN0 transmit value |
| can0_rx | output | 1 | CAN0 receive value |
| can4_en | input | 1 | CAN4 enable |
| can4_tx | input | 1 | CAN4 transmit value |
| can4_rx | output | 1 | CAN4 receive value |
| spi_en | input | 1 | SPI0 enable |
| spi_master | input | 1 | SPI0 mode: 1 master, 0 slave |
| spi_sck_o | input | 1 | SPI0 clock out |
| spi_mosi_o | input | 1 | SPI0 MOSI out |
| spi_ss_o | input | 1 | SPI0 select out |
| spi_miso_o | input | 1 | SPI0 MISO out |
| spi_sck_i | output | 1 | SPI0 clock in |
| spi_mosi_i | output | 1 | SPI0 MOSI in |
| spi_ss_i | output | 1 | SPI0 select in |
| spi_miso_i | output | 1 | SPI0 MISO in |

## Verification
A corrupted latch or direction bit appears on pad_oe or pad_out of a GPIO pin in the very cycle after the bad write. Data-register reads show it immediately. A wrong owner decision appears combinationally on the pad pins and the rx outputs, so it is visible in the same cycle that the enables or the route select change. A synchronizer that is one stage too short or too long appears in the input-register read and the rx outputs. The error shows one edge early or one edge late after each pad change.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int PORT_W = 8;
    localparam int IDX_W  = $clog2(PORT_W);
    localparam int SPI_W  = 4;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_PIN  = 8'h11;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 8'h12;

    typedef enum logic [2:0] {
        OWN_GPIO,
        OWN_C0_TX,
        OWN_C0_RX,
        OWN_C4_TX,
        OWN_C4_RX,
        OWN_SPI
    } owner_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
    } regs_t;

    typedef struct packed {
        logic [PORT_W-1:0] meta;
        logic [PORT_W-1:0] pin;
    } sync_t;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pin_o
);
    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pad_in;
        sync_d.pin  = sync_q.meta;
    end

    // Pad levels are sampled free-running; reset does not disturb them.
    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign pin_o = sync_q.pin;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] rdata,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                ADDR_DATA: regs_d.data = wdata;
                ADDR_DIR:  regs_d.dir  = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            ADDR_DATA: rdata = (regs_q.dir & regs_q.data) | (~regs_q.dir & pin_sync);
            ADDR_PIN:  rdata = pin_sync;
            ADDR_DIR:  rdata = regs_q.dir;
            default:   rdata = '0;
        endcase
    end

    assign data_q = regs_q.data;
    assign dir_q  = regs_q.dir;
endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner
    import gpio_mux_pkg::*;
(
    input  logic              can0_en,
    input  logic              can0_tx,
    input  logic              can4_en,
    input  logic              can4_tx,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic [SPI_W-1:0]  spi_out,
    input  logic [2:0]        route_sel,
    input  logic [PORT_W-1:0] data_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic              can0_rx,
    output logic              can4_rx,
    output logic [SPI_W-1:0]  spi_in
);
    logic [IDX_W-1:0] c0_tx_pin, c0_rx_pin, c4_tx_pin, c4_rx_pin;
    owner_e           owner_w [PORT_W];

    assign c0_tx_pin = route_sel[0] ? IDX_W'(3) : IDX_W'(1);
    assign c0_rx_pin = route_sel[0] ? IDX_W'(2) : IDX_W'(0);
    assign c4_tx_pin = route_sel[1] ? IDX_W'(5) : IDX_W'(7);
    assign c4_rx_pin = route_sel[1] ? IDX_W'(4) : IDX_W'(6);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        localparam logic [IDX_W-1:0] PI = IDX_W'(i);
        localparam logic [1:0]       PK = PI[1:0];
        owner_e own;
        logic   in_spi_grp;
        logic   spi_drive;
        logic   oe_l, out_l;

        // SPI group is the upper nibble by default, the lower one when routed.
        assign in_spi_grp = spi_en && (PI[IDX_W-1] != route_sel[2]);
        assign spi_drive  = spi_master ? (PK != 2'd0) : (PK == 2'd0);

        always_comb begin
            if (can0_en && c0_tx_pin == PI)      own = OWN_C0_TX;
            else if (can0_en && c0_rx_pin == PI) own = OWN_C0_RX;
            else if (can4_en && c4_tx_pin == PI) own = OWN_C4_TX;
            else if (can4_en && c4_rx_pin == PI) own = OWN_C4_RX;
            else if (in_spi_grp)                 own = OWN_SPI;
            else                                 own = OWN_GPIO;
        end

        always_comb begin
            case (own)
                OWN_C0_TX: begin oe_l = 1'b1;      out_l = can0_tx; end
                OWN_C4_TX: begin oe_l = 1'b1;      out_l = can4_tx; end
                OWN_C0_RX,
                OWN_C4_RX: begin oe_l = 1'b0;      out_l = 1'b0; end
                OWN_SPI:   begin oe_l = spi_drive; out_l = spi_drive & spi_out[PK]; end
                default:   begin oe_l = dir_q[i];  out_l = dir_q[i] & data_q[i]; end
            endcase
        end

        assign pad_oe[i]  = oe_l;
        assign pad_out[i] = out_l;
        assign owner_w[i] = own;
    end

    assign can0_rx = can0_en ? pin_sync[c0_rx_pin] : 1'b1;
    assign can4_rx = can4_en ? pin_sync[c4_rx_pin] : 1'b1;

    for (genvar k = 0; k < SPI_W; k++) begin : g_spi_in
        logic [IDX_W-1:0] sp;
        assign sp        = {~route_sel[2], 2'(k)};
        assign spi_in[k] = (owner_w[sp] == OWN_SPI) ? pin_sync[sp] : 1'b0;
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pad_in,
    output logic [7:0] pad_oe,
    output logic [7:0] pad_out,
    input  logic [2:0] route_sel,
    input  logic       can0_en,
    input  logic       can0_tx,
    output logic       can0_rx,
    input  logic       can4_en,
    input  logic       can4_tx,
    output logic       can4_rx,
    input  logic       spi_en,
    input  logic       spi_master,
    input  logic       spi_sck_o,
    input  logic       spi_mosi_o,
    input  logic       spi_ss_o,
    input  logic       spi_miso_o,
    output logic       spi_sck_i,
    output logic       spi_mosi_i,
    output logic       spi_ss_i,
    output logic       spi_miso_i
);
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;
    logic [SPI_W-1:0]  spi_in;

    gpio_pad_sync u_sync (
        .clk    (clk),
        .pad_in (pad_in),
        .pin_o  (pin_sync)
    );

    gpio_port_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .pin_sync (pin_sync),
        .rdata    (rdata),
        .data_q   (data_q),
        .dir_q    (dir_q)
    );

    gpio_pin_owner u_owner (
        .can0_en    (can0_en),
        .can0_tx    (can0_tx),
        .can4_en    (can4_en),
        .can4_tx    (can4_tx),
        .spi_en     (spi_en),
        .spi_master (spi_master),
        .spi_out    ({spi_sck_o, spi_mosi_o, spi_ss_o, spi_miso_o}),
        .route_sel  (route_sel),
        .data_q     (data_q),
        .dir_q      (dir_q),
        .pin_sync   (pin_sync),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .can0_rx    (can0_rx),
        .can4_rx    (can4_rx),
        .spi_in     (spi_in)
    );

    assign {spi_sck_i, spi_mosi_i, spi_ss_i, spi_miso_i} = spi_in;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pad_in,
    input logic [7:0] pad_oe,
    input logic [7:0] pad_out,
    input logic [2:0] route_sel,
    input logic       can0_en,
    input logic       can0_tx,
    input logic       can4_en,
    input logic       can4_tx,
    input logic       spi_en,
    input logic       spi_master,
    input logic       spi_ss_o,
    input logic [7:0] data_q,
    input logic [7:0] dir_q
);
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> (data_q == 8'h00 && dir_q == 8'h00));

    p_can0_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (can0_en && !route_sel[0]) |-> (pad_oe[1] && pad_out[1] == can0_tx && !pad_oe[0]));

    p_can4_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (can4_en && route_sel[1]) |-> (pad_oe[5] && pad_out[5] == can4_tx && !pad_oe[4]));

    p_spi_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master && !route_sel[2] && !can4_en)
            |-> (pad_oe[7:4] == 4'b1110 && pad_out[5] == spi_ss_o));

    p_data_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h10) |=> (data_q == $past(wdata)));

    p_pin_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h11) |-> (rdata == $past(pad_in, 2)));
endmodule

bind gpio_mux_port gpio_mux_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .route_sel  (route_sel),
    .can0_en    (can0_en),
    .can0_tx    (can0_tx),
    .can4_en    (can4_en),
    .can4_tx    (can4_tx),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .spi_ss_o   (spi_ss_o),
    .data_q     (data_q),
    .dir_q      (dir_q)
);

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h12;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pad_in = 8'hA5;
    logic [7:0] pad_oe, pad_out;
    logic [2:0] route_sel = 3'b000;
    logic       can0_en = 1'b0, can0_tx = 1'b0, can0_rx;
    logic       can4_en = 1'b0, can4_tx = 1'b0, can4_rx;
    logic       spi_en = 1'b0, spi_master = 1'b0;
    logic       spi_sck_o = 1'b0, spi_mosi_o = 1'b0, spi_ss_o = 1'b0, spi_miso_o = 1'b0;
    logic       spi_sck_i, spi_mosi_i, spi_ss_i, spi_miso_i;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_mux_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .route_sel(route_sel),
        .can0_en(can0_en), .can0_tx(can0_tx), .can0_rx(can0_rx),
        .can4_en(can4_en), .can4_tx(can4_tx), .can4_rx(can4_rx),
        .spi_en(spi_en), .spi_master(spi_master),
        .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o), .spi_ss_o(spi_ss_o), .spi_miso_o(spi_miso_o),
        .spi_sck_i(spi_sck_i), .spi_mosi_i(spi_mosi_i), .spi_ss_i(spi_ss_i), .spi_miso_i(spi_miso_i)
    );

    // Behavioural reference state
    logic [7:0] m_latch = 8'h00, m_dir = 8'h00;
    logic [7:0] m_hist [2] = '{8'h00, 8'h00};
    int         cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        m_hist[1] <= m_hist[0];
        m_hist[0] <= pad_in;
        if (!rst_n) begin
            m_latch <= 8'h00;
            m_dir   <= 8'h00;
        end else if (wr_en) begin
            if (addr == 8'h10) m_latch <= wdata;
            if (addr == 8'h12) m_dir   <= wdata;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("[TB] FAIL %s at cycle %0d: actual %02h expected %02h", tag, cyc, act, exp);
        end
    endtask

    // Claim-based ownership model: each peripheral in priority order takes free pins.
    task automatic compare_all();
        int         who [8];
        logic [7:0] e_oe = 8'h00, e_out = 8'h00, e_rd;
        logic [3:0] e_spi = 4'h0;
        logic [3:0] s_val;
        logic [7:0] seen;
        int t0, r0, t4, r4, base;
        seen = m_hist[1];
        // Only meaningful after the synchronizer has filled since time zero.
        if (cyc < 3) return;
        for (int p = 0; p < 8; p++) who[p] = 0;
        t0 = route_sel[0] ? 3 : 1;  r0 = route_sel[0] ? 2 : 0;
        t4 = route_sel[1] ? 5 : 7;  r4 = route_sel[1] ? 4 : 6;
        base = route_sel[2] ? 0 : 4;
        s_val = {spi_sck_o, spi_mosi_o, spi_ss_o, spi_miso_o};
        if (can0_en) begin
            who[t0] = 1; e_oe[t0] = 1'b1; e_out[t0] = can0_tx;
            who[r0] = 1;
        end
        if (can4_en) begin
            if (who[t4] == 0) begin who[t4] = 2; e_oe[t4] = 1'b1; e_out[t4] = can4_tx; end
            if (who[r4] == 0) who[r4] = 2;
        end
        if (spi_en) begin
            for (int k = 0; k < 4; k++) begin
                if (who[base+k] == 0) begin
                    logic drv;
                    who[base+k] = 3;
                    drv = spi_master ? (k != 0) : (k == 0);
                    e_oe[base+k]  = drv;
                    e_out[base+k] = drv & s_val[k];
                    e_spi[k]      = seen[base+k];
                end
            end
        end
        for (int p = 0; p < 8; p++) begin
            if (who[p] == 0) begin
                e_oe[p]  = m_dir[p];
                e_out[p] = m_dir[p] & m_latch[p];
            end
        end
        case (addr)
            8'h10:   e_rd = (m_dir & m_latch) | (~m_dir & seen);
            8'h11:   e_rd = seen;
            8'h12:   e_rd = m_dir;
            default: e_rd = 8'h00;
        endcase
        chk(pad_oe, e_oe, "R1 pad_oe");
        chk(pad_out, e_out, "R6 pad_out");
        chk(rdata, e_rd, "R7 rdata");
        chk({7'd0, can0_rx}, {7'd0, can0_en ? seen[r0] : 1'b1}, "R3 can0_rx");
        chk({7'd0, can4_rx}, {7'd0, can4_en ? seen[r4] : 1'b1}, "R3 can4_rx");
        chk({4'd0, spi_sck_i, spi_mosi_i, spi_ss_i, spi_miso_i}, {4'd0, e_spi}, "R5 spi_in");
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (4) step();
        // R2 reset state
        chk(pad_oe, 8'h00, "R2 pad_oe in reset");
        chk(rdata, 8'h00, "R2 dir reads zero");
        rst_n = 1'b1;
        step();
        bus_write(8'h12, 8'h0F);
        bus_write(8'h10, 8'h5A);
        addr = 8'h10; step();
        chk(rdata, 8'hAA, "R7 mixed read");
        chk(pad_oe, 8'h0F, "R6 oe from dir");
        chk(pad_out, 8'h0A, "R6 out from latch");
        // R8 write to input register ignored
        bus_write(8'h11, 8'hFF);
        addr = 8'h11; step();
        chk(rdata, 8'hA5, "R8 pin read");
        addr = 8'h10; step();
        chk(rdata, 8'hAA, "R8 latch unchanged");
        // R9 unmapped address
        bus_write(8'h20, 8'hFF);
        addr = 8'h20; step();
        chk(rdata, 8'h00, "R9 unmapped read");
        addr = 8'h12; step();
        chk(rdata, 8'h0F, "R9 dir unchanged");
        // R11 two-edge latency
        pad_in = 8'h3C; addr = 8'h11;
        step();
        chk(rdata, 8'hA5, "R11 after one edge");
        step();
        chk(rdata, 8'h3C, "R11 after two edges");
        // R3 CAN0 default pins
        can0_en = 1'b1; can0_tx = 1'b0; step();
        chk(pad_oe[3:0], 4'b1110, "R3 can0 oe");
        chk(pad_out[3:0], 4'b1000, "R3 can0 out");
        chk({7'd0, can0_rx}, 8'h00, "R3 can0 rx");
        can0_tx = 1'b1; step();
        chk(pad_out[3:0], 4'b1010, "R3 can0 tx high");
        // R10 latch written while owned
        can0_tx = 1'b0;
        bus_write(8'h10, 8'hFF);
        chk(pad_out[1:0], 2'b00, "R10 owned pin keeps tx");
        can0_en = 1'b0; step();
        chk(pad_out[3:0], 4'hF, "R10 latch after release");
        chk(pad_oe[3:0], 4'hF, "R10 oe after release");
        chk({7'd0, can0_rx}, 8'h01, "R3 rx idle when disabled");
        // R4 routing
        can0_en = 1'b1; can0_tx = 1'b1; route_sel = 3'b001; step();
        chk(pad_oe[3:0], 4'b1011, "R4 can0 alt oe");
        chk(pad_out[3:0], 4'b1011, "R4 can0 alt out");
        can0_en = 1'b0; route_sel = 3'b111; step();
        chk(pad_oe, 8'h0F, "R4 route ignored when disabled");
        chk(pad_out, 8'h0F, "R4 route ignored out");
        can4_en = 1'b1; can4_tx = 1'b1; route_sel = 3'b010; step();
        chk(pad_oe, 8'h2F, "R4 can4 alt oe");
        chk(pad_out, 8'h2F, "R4 can4 alt out");
        // R1 priority
        route_sel = 3'b000; spi_en = 1'b1; spi_master = 1'b1;
        {spi_sck_o, spi_mosi_o, spi_ss_o, spi_miso_o} = 4'b1011; step();
        chk(pad_oe, 8'hAF, "R1 can4 over spi oe");
        chk(pad_out, 8'hAF, "R1 can4 over spi out");
        can4_en = 1'b0; can0_en = 1'b1; route_sel = 3'b101; step();
        chk(pad_oe, 8'h0A, "R1 can0 over spi oe");
        chk(pad_out, 8'h0A, "R1 can0 over spi out");
        // R5 slave mode
        can0_en = 1'b0; route_sel = 3'b000; spi_master = 1'b0; step();
        chk(pad_oe, 8'h1F, "R5 slave oe");
        chk(pad_out, 8'h1F, "R5 slave out");
        chk({4'd0, spi_sck_i, spi_mosi_i, spi_ss_i, spi_miso_i}, 8'h03, "R5 spi inputs");
        // Random phase against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            wr_en = r[0]; addr = r[1] ? 8'h10 : (r[2] ? 8'h12 : (r[3] ? 8'h11 : 8'h30));
            wdata = r[15:8]; pad_in = r[23:16]; route_sel = r[26:24];
            can0_en = r[27]; can4_en = r[28]; spi_en = r[29]; spi_master = r[30];
            can0_tx = r[31]; can4_tx = r[4];
            {spi_sck_o, spi_mosi_o, spi_ss_o, spi_miso_o} = r[7:4];
            step();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("[TB] FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule